// File: doc/BRIEF.md
# Priority Pin Crossbar Allocator

This block routes the signals of a fixed set of on-chip digital peripherals onto a bank of general-purpose pads. Each peripheral function has a fixed rank. Every enabled function takes the lowest-numbered pad that is still free, so the pads are packed from pad 0 upward without gaps. The pad a function lands on therefore depends on which higher-ranked functions are enabled.

Three 8-bit enable registers are written through a plain write strobe, address and data. The pad mapping is combinational from those registers. For every pad, the block returns:
- the drive value and output enable of the owning function, or of the pad's own GPIO latch when no function owns it;
- a select index naming the owner.

Each function's input is read back from its pad. A function that is disabled, or that found no pad, sees a fixed idle level instead. A sticky flag records that more functions were enabled than there are pads.

The interface has no stream data path. Every pin is a plain control or status signal, with no valid/ready handshake and no back-pressure. A configuration write is accepted on every cycle in which the strobe is high.

Top module: `pinmux_prio`

## Requirements
- R1: The enabled functions take pads in rank order. The k-th enabled function, counting from 0, owns pad k, so the owned pads always form an unbroken run that starts at pad 0.
- R2: The 28 functions are ranked as follows, highest first, and a pad's select value is the rank plus one.
  - UART A: transmit, receive.
  - SPI: clock, master-in, master-out, slave select.
  - SMBus: data, clock.
  - UART B: transmit, receive.
  - Capture/compare: outputs 0 to 4.
  - Counter clock input, comparator 0 output, comparator 1 output.
  - Timer 0 input, interrupt 0, timer 1 input, interrupt 1.
  - Timer 2 input, timer 2 trigger, timer 4 input, timer 4 trigger.
  - Clock output, then converter start last.
- R3: When UART A is enabled, its transmit owns pad 0 (select 1) and its receive owns pad 1 (select 2).
- R4: The enable bits are laid out as follows.
  - Register 0: bit 2 UART A, bit 1 SPI, bit 0 SMBus, bits 5:3 capture/compare count, bit 6 counter clock, bit 7 comparator 0.
  - Register 1: bit 0 comparator 1, bit 1 timer 0, bit 2 interrupt 0, bit 3 timer 1, bit 4 interrupt 1, bit 5 timer 2, bit 6 timer 2 trigger, bit 7 clock output.
  - Register 2: bit 0 converter start, bit 2 UART B, bit 3 timer 4, bit 4 timer 4 trigger.
  - A serial peripheral's single enable bit claims all of its functions at once.
- R5: The capture/compare count field enables outputs 0 up to count-1, always from output 0. Field values 6 and 7 act as 5.
- R6: A pad that no function owns has select 0 and drives its own gpio_out and gpio_oe bits.
- R7: A pad owned by function f drives fn_out[f] and fn_oe[f].
- R8: An enabled function that owns a pad receives that pad's pad_in. Any other function receives its idle level:
  - 1 for ranks 0 to 9 (the serial lines) and for ranks 19 and 21 (the interrupts);
  - 0 for every other rank.
- R9: After reset all three registers are zero, every pad has select 0, and the overflow flag is 0.
- R10: A write takes effect in the cycle after the strobe edge. A write to address 3 changes nothing.
- R11: When more functions are enabled than NUM_PINS, the lowest-ranked functions beyond the last pad get no pad. ovf is set one cycle later and stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address (0..2 valid) |
| cfg_wdata | input | 8 | Register write data |
| fn_out | input | 28 | Per-function drive value, index = rank |
| fn_oe | input | 28 | Per-function output enable, index = rank |
| fn_in | output | 28 | Per-function input routed from its pad, or idle level |
| gpio_out | input | NUM_PINS | GPIO latch value per pad |
| gpio_oe | input | NUM_PINS | GPIO output enable per pad |
| pad_in | input | NUM_PINS | Sampled pad levels |
| pad_out | output | NUM_PINS | Pad drive value |
| pad_oe | output | NUM_PINS | Pad output enable |
| pad_sel | output | NUM_PINS*5 | Per-pad owner, 5 bits per pad, 0 = GPIO |
| ovf | output | 1 | Sticky pad-overflow flag |

## Verification
Several properties are checked on every cycle by assertions:
- the owned pads form a gap-free run from pad 0;
- the number of owned pads equals the smaller of the demand and the pad count;
- UART A sits on pads 0 and 1 whenever it is enabled;
- unowned pads follow their GPIO bits;
- disabled functions see their idle level;
- the overflow flag never clears;
- a write to the unused address leaves the registers unchanged.

Only the bench scenarios show that each function lands on exactly the pad a rank-order walk predicts, across random and directed enable patterns. These include the capture/compare count saturating at 5 and overflow on a 16-pad instance. The bench also checks that owned pads carry the right function's data in both directions.

// File: rtl/pinmux_prio_pkg.sv
package pinmux_prio_pkg;
  localparam int NUM_FN   = 28;
  localparam int FN_IDX_W = $clog2(NUM_FN + 1);
  localparam int CC_MAX   = 5;

  // Idle input level per rank: serial lines (0..9) and interrupts (19, 21) idle high
  localparam logic [NUM_FN-1:0] FN_IDLE_HI = 28'h02803FF;

  typedef enum logic [FN_IDX_W-1:0] {
    FN_UA_TX, FN_UA_RX, FN_SPI_CLK, FN_SPI_MISO, FN_SPI_MOSI, FN_SPI_SEL,
    FN_I2C_DAT, FN_I2C_CLK, FN_UB_TX, FN_UB_RX,
    FN_CC0, FN_CC1, FN_CC2, FN_CC3, FN_CC4,
    FN_CNT_CLK, FN_CMP0, FN_CMP1, FN_TM0, FN_IRQ0, FN_TM1, FN_IRQ1,
    FN_TM2, FN_TM2_TRIG, FN_TM4, FN_TM4_TRIG, FN_CLK_OUT, FN_ADC_START
  } fn_id_e;

  typedef struct packed {
    logic [7:0] r2;
    logic [7:0] r1;
    logic [7:0] r0;
  } cfg_t;
endpackage

// File: rtl/pinmux_prio_cfg.sv
module pinmux_prio_cfg
  import pinmux_prio_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output cfg_t       cfg
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (we) begin
      case (addr)
        2'd0:    cfg.r0 <= wdata;
        2'd1:    cfg.r1 <= wdata;
        2'd2:    cfg.r2 <= wdata;
        default: ;
      endcase
    end
  end

  // R10: the unused address leaves all registers untouched
  assert_unmapped_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == 2'd3) |=> $stable(cfg));
endmodule

// File: rtl/pinmux_prio_decode.sv
module pinmux_prio_decode
  import pinmux_prio_pkg::*;
(
  input  cfg_t              cfg,
  output logic [NUM_FN-1:0] fn_en
);
  logic [2:0] cc_cnt;
  assign cc_cnt = (cfg.r0[5:3] > 3'(CC_MAX)) ? 3'(CC_MAX) : cfg.r0[5:3];

  always_comb begin
    fn_en = '0;
    fn_en[FN_UA_TX]     = cfg.r0[2];
    fn_en[FN_UA_RX]     = cfg.r0[2];
    fn_en[FN_SPI_CLK]   = cfg.r0[1];
    fn_en[FN_SPI_MISO]  = cfg.r0[1];
    fn_en[FN_SPI_MOSI]  = cfg.r0[1];
    fn_en[FN_SPI_SEL]   = cfg.r0[1];
    fn_en[FN_I2C_DAT]   = cfg.r0[0];
    fn_en[FN_I2C_CLK]   = cfg.r0[0];
    fn_en[FN_UB_TX]     = cfg.r2[2];
    fn_en[FN_UB_RX]     = cfg.r2[2];
    for (int k = 0; k < CC_MAX; k++)
      fn_en[int'(FN_CC0) + k] = (32'(cc_cnt) > k);
    fn_en[FN_CNT_CLK]   = cfg.r0[6];
    fn_en[FN_CMP0]      = cfg.r0[7];
    fn_en[FN_CMP1]      = cfg.r1[0];
    fn_en[FN_TM0]       = cfg.r1[1];
    fn_en[FN_IRQ0]      = cfg.r1[2];
    fn_en[FN_TM1]       = cfg.r1[3];
    fn_en[FN_IRQ1]      = cfg.r1[4];
    fn_en[FN_TM2]       = cfg.r1[5];
    fn_en[FN_TM2_TRIG]  = cfg.r1[6];
    fn_en[FN_TM4]       = cfg.r2[3];
    fn_en[FN_TM4_TRIG]  = cfg.r2[4];
    fn_en[FN_CLK_OUT]   = cfg.r1[7];
    fn_en[FN_ADC_START] = cfg.r2[0];
  end
endmodule

// File: rtl/pinmux_prio_alloc.sv
module pinmux_prio_alloc
  import pinmux_prio_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic [NUM_FN-1:0]          fn_en,
  output logic [NUM_FN*FN_IDX_W-1:0] pos_flat,
  output logic [NUM_FN-1:0]          placed,
  output logic [FN_IDX_W-1:0]        demand
);
  localparam int CW = FN_IDX_W;

  logic [CW-1:0] pos_a [NUM_FN];

  // prefix count of enabled higher-ranked functions = target pad
  for (genvar f = 0; f < NUM_FN; f++) begin : g_pos
    if (f == 0) begin : g_first
      assign pos_a[f] = '0;
    end else begin : g_next
      assign pos_a[f] = pos_a[f-1] + CW'(fn_en[f-1]);
    end
    assign placed[f] = fn_en[f] && (32'(pos_a[f]) < NUM_PINS);
    assign pos_flat[f*CW +: CW] = pos_a[f];
  end

  assign demand = pos_a[NUM_FN-1] + CW'(fn_en[NUM_FN-1]);
endmodule

// File: rtl/pinmux_prio_route.sv
module pinmux_prio_route
  import pinmux_prio_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic [NUM_FN*FN_IDX_W-1:0]   pos_flat,
  input  logic [NUM_FN-1:0]            placed,
  input  logic [NUM_FN-1:0]            fn_out,
  input  logic [NUM_FN-1:0]            fn_oe,
  output logic [NUM_FN-1:0]            fn_in,
  input  logic [NUM_PINS-1:0]          gpio_out,
  input  logic [NUM_PINS-1:0]          gpio_oe,
  input  logic [NUM_PINS-1:0]          pad_in,
  output logic [NUM_PINS-1:0]          pad_out,
  output logic [NUM_PINS-1:0]          pad_oe,
  output logic [NUM_PINS*FN_IDX_W-1:0] pad_sel
);
  localparam int CW   = FN_IDX_W;
  localparam int EXTW = 2 ** CW;

  logic [CW-1:0]   pos_a [NUM_FN];
  logic [EXTW-1:0] pad_in_ext;

  assign pad_in_ext = EXTW'(pad_in);

  for (genvar f = 0; f < NUM_FN; f++) begin : g_in
    assign pos_a[f] = pos_flat[f*CW +: CW];
    assign fn_in[f] = placed[f] ? pad_in_ext[pos_a[f]] : FN_IDLE_HI[f];
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pad
    logic [CW-1:0] sel;
    logic [CW-1:0] fidx;
    always_comb begin
      sel = '0;
      for (int f = 0; f < NUM_FN; f++)
        if (placed[f] && pos_a[f] == CW'(p)) sel = CW'(f + 1);
    end
    assign fidx       = sel - 1'b1;
    assign pad_out[p] = (sel == '0) ? gpio_out[p] : fn_out[fidx];
    assign pad_oe[p]  = (sel == '0) ? gpio_oe[p]  : fn_oe[fidx];
    assign pad_sel[p*CW +: CW] = sel;
  end
endmodule

// File: rtl/pinmux_prio.sv
module pinmux_prio
  import pinmux_prio_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_we,
  input  logic [1:0]                   cfg_addr,
  input  logic [7:0]                   cfg_wdata,
  input  logic [NUM_FN-1:0]            fn_out,
  input  logic [NUM_FN-1:0]            fn_oe,
  output logic [NUM_FN-1:0]            fn_in,
  input  logic [NUM_PINS-1:0]          gpio_out,
  input  logic [NUM_PINS-1:0]          gpio_oe,
  input  logic [NUM_PINS-1:0]          pad_in,
  output logic [NUM_PINS-1:0]          pad_out,
  output logic [NUM_PINS-1:0]          pad_oe,
  output logic [NUM_PINS*FN_IDX_W-1:0] pad_sel,
  output logic                         ovf
);
  localparam int CW = FN_IDX_W;

  cfg_t                  cfg;
  logic [NUM_FN-1:0]     fn_en;
  logic [NUM_FN*CW-1:0]  pos_flat;
  logic [NUM_FN-1:0]     placed;
  logic [CW-1:0]         demand;
  logic                  ovf_q;

  pinmux_prio_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata), .cfg(cfg)
  );

  pinmux_prio_decode u_decode (.cfg(cfg), .fn_en(fn_en));

  pinmux_prio_alloc #(.NUM_PINS(NUM_PINS)) u_alloc (
    .fn_en(fn_en), .pos_flat(pos_flat), .placed(placed), .demand(demand)
  );

  pinmux_prio_route #(.NUM_PINS(NUM_PINS)) u_route (
    .pos_flat(pos_flat), .placed(placed), .fn_out(fn_out), .fn_oe(fn_oe), .fn_in(fn_in),
    .gpio_out(gpio_out), .gpio_oe(gpio_oe), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_sel(pad_sel)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) ovf_q <= 1'b0;
    else if (32'(demand) > NUM_PINS) ovf_q <= 1'b1;
  end
  assign ovf = ovf_q;

  // ---------------- assertions ----------------
  logic [NUM_PINS-1:0] used;
  int                  exp_fill;
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_used
    assign used[p] = (pad_sel[p*CW +: CW] != '0);
  end
  assign exp_fill = (32'(demand) > NUM_PINS) ? NUM_PINS : 32'(demand);

  // R11: owned pad count tracks demand, capped at the pad count
  assert_fill_count_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(used) == exp_fill);

  // R11: overflow is sticky
  assert_ovf_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);

  for (genvar p = 0; p + 1 < NUM_PINS; p++) begin : g_gap
    // R1: no free pad below an owned pad
    assert_no_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !used[p] |-> !used[p+1]);
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_gpio
    // R6: unowned pads follow the GPIO latch
    assert_gpio_fallback_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !used[p] |-> (pad_out[p] == gpio_out[p] && pad_oe[p] == gpio_oe[p]));
  end

  for (genvar f = 0; f < NUM_FN; f++) begin : g_idle
    // R8: disabled functions see their idle level
    assert_disabled_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !fn_en[f] |-> fn_in[f] == FN_IDLE_HI[f]);
  end

  if (NUM_PINS >= 2) begin : g_ua
    // R3: UART A pinned to pads 0 and 1
    assert_uart_a_fixed_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cfg.r0[2] |-> (pad_sel[0 +: CW] == CW'(1) && pad_sel[CW +: CW] == CW'(2)));
  end
endmodule

// File: tb/pinmux_prio_bench.sv
module pinmux_prio_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NF = 28;
  localparam int NP = 32;
  localparam int NS = 16;
  localparam int W  = 5;
  localparam logic [NF-1:0] IDLE = 28'h02803FF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [NF-1:0] fn_out = '0, fn_oe = '0, fn_in_b, fn_in_s;
  logic [NP-1:0] gpio_out_b = '0, gpio_oe_b = '0, pad_in_b = '0, pad_out_b, pad_oe_b;
  logic [NS-1:0] gpio_out_s = '0, gpio_oe_s = '0, pad_in_s = '0, pad_out_s, pad_oe_s;
  logic [NP*W-1:0] sel_b;
  logic [NS*W-1:0] sel_s;
  logic ovf_b, ovf_s;

  int n_chk = 0, n_bad = 0;
  logic [7:0] sh0 = '0, sh1 = '0, sh2 = '0;
  logic exp_ovf_s = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pinmux_prio #(.NUM_PINS(NP)) u_pinmux_prio (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .fn_out(fn_out), .fn_oe(fn_oe), .fn_in(fn_in_b),
    .gpio_out(gpio_out_b), .gpio_oe(gpio_oe_b), .pad_in(pad_in_b),
    .pad_out(pad_out_b), .pad_oe(pad_oe_b), .pad_sel(sel_b), .ovf(ovf_b)
  );

  pinmux_prio #(.NUM_PINS(NS)) u_pinmux_prio_small (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .fn_out(fn_out), .fn_oe(fn_oe), .fn_in(fn_in_s),
    .gpio_out(gpio_out_s), .gpio_oe(gpio_oe_s), .pad_in(pad_in_s),
    .pad_out(pad_out_s), .pad_oe(pad_oe_s), .pad_sel(sel_s), .ovf(ovf_s)
  );

  function automatic logic [NF-1:0] ref_en(logic [7:0] a, logic [7:0] b, logic [7:0] c);
    logic [NF-1:0] e;
    int n;
    e = '0;
    e[1:0] = {2{a[2]}};
    e[5:2] = {4{a[1]}};
    e[7:6] = {2{a[0]}};
    e[9:8] = {2{c[2]}};
    n = int'(a[5:3]);
    if (n > 5) n = 5;
    for (int k = 0; k < 5; k++) e[10+k] = (k < n);
    e[15] = a[6]; e[16] = a[7]; e[17] = b[0]; e[18] = b[1]; e[19] = b[2];
    e[20] = b[3]; e[21] = b[4]; e[22] = b[5]; e[23] = b[6];
    e[24] = c[3]; e[25] = c[4]; e[26] = b[7]; e[27] = c[0];
    return e;
  endfunction

  // expected owner of pad p (rank+1, 0 = GPIO)
  function automatic int ref_sel(logic [NF-1:0] e, int p);
    int k = 0;
    for (int f = 0; f < NF; f++) if (e[f]) begin
      if (k == p) return f + 1;
      k++;
    end
    return 0;
  endfunction

  // expected pad of function f, -1 if none
  function automatic int ref_pad(logic [NF-1:0] e, int f, int np);
    int k = 0;
    if (!e[f]) return -1;
    for (int g = 0; g < f; g++) if (e[g]) k++;
    return (k < np) ? k : -1;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    cfg_addr = a; cfg_wdata = d; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic apply(logic [7:0] a, logic [7:0] b, logic [7:0] c);
    wr(2'd0, a); wr(2'd1, b); wr(2'd2, c);
    sh0 = a; sh1 = b; sh2 = c;
    if ($countones(ref_en(a, b, c)) > NS) exp_ovf_s = 1'b1;
    @(negedge clk);
  endtask

  // full comparison of both instances against the rank walk
  task automatic check_map(string tag);
    logic [NF-1:0] e;
    int s, pd;
    e = ref_en(sh0, sh1, sh2);
    fn_out = NF'($urandom); fn_oe = NF'($urandom);
    gpio_out_b = $urandom; gpio_oe_b = $urandom; pad_in_b = $urandom;
    gpio_out_s = NS'($urandom); gpio_oe_s = NS'($urandom); pad_in_s = NS'($urandom);
    #1;
    for (int p = 0; p < NP; p++) begin
      s = ref_sel(e, p);
      chk(int'(sel_b[p*W +: W]) == s, {tag, " R1 R2 sel"}, int'(sel_b[p*W +: W]), s);
      if (s == 0)
        chk(pad_out_b[p] == gpio_out_b[p] && pad_oe_b[p] == gpio_oe_b[p], {tag, " R6 gpio"},
            int'({pad_out_b[p], pad_oe_b[p]}), int'({gpio_out_b[p], gpio_oe_b[p]}));
      else
        chk(pad_out_b[p] == fn_out[s-1] && pad_oe_b[p] == fn_oe[s-1], {tag, " R7 drive"},
            int'({pad_out_b[p], pad_oe_b[p]}), int'({fn_out[s-1], fn_oe[s-1]}));
    end
    for (int p = 0; p < NS; p++) begin
      s = ref_sel(e, p);
      chk(int'(sel_s[p*W +: W]) == s, {tag, " R11 small sel"}, int'(sel_s[p*W +: W]), s);
    end
    for (int f = 0; f < NF; f++) begin
      pd = ref_pad(e, f, NP);
      chk(fn_in_b[f] == ((pd >= 0) ? pad_in_b[pd] : IDLE[f]), {tag, " R8 input"},
          int'(fn_in_b[f]), int'((pd >= 0) ? pad_in_b[pd] : IDLE[f]));
      pd = ref_pad(e, f, NS);
      chk(fn_in_s[f] == ((pd >= 0) ? pad_in_s[pd] : IDLE[f]), {tag, " R8 R11 small input"},
          int'(fn_in_s[f]), int'((pd >= 0) ? pad_in_s[pd] : IDLE[f]));
    end
    chk(ovf_b == 1'b0, {tag, " R11 ovf big"}, int'(ovf_b), 0);
    chk(ovf_s == exp_ovf_s, {tag, " R11 ovf small"}, int'(ovf_s), int'(exp_ovf_s));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h5eed_0017));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    check_map("R9 reset");
    chk(ovf_s == 1'b0, "R9 ovf", int'(ovf_s), 0);

    apply(8'h04, 8'h00, 8'h00);            // R3 UART A alone
    check_map("R3 uart_a");
    chk(sel_b[0 +: W] == 5'd1 && sel_b[W +: W] == 5'd2, "R3 pads", int'(sel_b[2*W-1:0]), 65);

    apply(8'h02, 8'h00, 8'h00);            // R4 SPI claims four pads
    check_map("R4 spi");
    apply(8'h07, 8'h00, 8'h04);            // R4 all serial peripherals
    check_map("R4 serial");
    apply(8'h18, 8'h00, 8'h00);            // R5 count 3
    check_map("R5 cc3");
    apply(8'h38, 8'h00, 8'h00);            // R5 count 7 acts as 5
    check_map("R5 cc7");
    apply(8'h00, 8'h80, 8'h01);            // R2 lowest ranks alone
    check_map("R2 low");

    // R10 write to address 3 ignored
    wr(2'd3, 8'hFF);
    @(negedge clk);
    check_map("R10 addr3");

    apply(8'hFF, 8'hFF, 8'hFF);            // R11 everything: small overflows
    check_map("R11 full");
    apply(8'h00, 8'h00, 8'h00);            // R11 sticky after demand drops
    check_map("R11 sticky");

    for (int i = 0; i < 150; i++) begin
      apply(8'($urandom), 8'($urandom), 8'($urandom));
      check_map("R1 random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule